// File: doc/BRIEF.md
# PWM Channel with Locked Update

A single-channel pulse-width modulator with four 32-bit registers on a simple synchronous read/write port. A counter advances once per input clock, with no prescaling. Each period starts in the duty phase and then moves to the inactive phase, so the output is left-aligned. Two independent control bits set the level driven in each phase, so either polarity can be selected.

Software does not write the running waveform directly. Period, duty and both level bits are copied into an active set only at a period boundary, or at any time while the channel is stopped. A lock bit in the control register blocks that copy. Software sets the lock, writes a new period and duty, and then clears the lock in the same control write that changes polarity. All three changes then take effect together on the first cycle of the next period. Reads of period and duty return the values last written. Reads of the counter return its live value.

Top module: `pwm_lock_chan`

## Requirements
- R1: After reset, all four registers read 0 and `pwm_o` is 0.
- R2: The register offsets are counter 0x0, period 0x4, duty 0x8 and control 0xC. Period, duty and control read back the last value written. The counter is read-only: writes to offset 0x0 are ignored, and reads return the live count.
- R3: The channel runs only when control bit 0 (enable) and bit 1 (continuous) are both 1. Otherwise the counter is held at 0 and `pwm_o` drives the inactive level.
- R4: While running, the counter goes 0, 1, …, period−1 and then wraps to 0. On enabling, the cycle after the enabling write shows count 0.
- R5: While running, `pwm_o` is at the duty level while the count is below duty, and at the inactive level otherwise. The duty level is control bit 3 (1 = high). The inactive level is control bit 4 (1 = high).
- R6: If duty is greater than or equal to a nonzero period, `pwm_o` stays at the duty level. If period is 0, the counter stays at 0 and `pwm_o` stays at the inactive level.
- R7: With the lock clear, a write to period, duty or the level bits during a running period does not change the rest of that period. The new value applies from the next count-0 cycle.
- R8: While control bit 6 (lock) is 1, writes to period and duty are stored and read back, but the running waveform keeps its previous period and duty.
- R9: A control write that clears the lock and changes bits 3 and 4 makes the staged period, the staged duty and the new levels all take effect on the first cycle of the next period. None of them changes before that cycle.
- R10: While the channel is stopped and the lock is clear, the active set follows the registers. Enabling therefore starts with the latest period, duty and levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one count per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, available in the same cycle |
| pwm_o | output | 1 | PWM output |

## Verification
The main waveform is exercised with a table of period, duty and level combinations. The table covers an ordinary ratio, zero duty, duty equal to the period, duty above the period with inverted levels, zero period, a one-cycle period, and both levels high. Together these separate the compare rule, the wrap point and the two level bits. Directed sequences change duty in the middle of a period with the lock clear, and stage a new period and duty under the lock. They then release the lock together with a polarity flip in the middle of a period. Each check confirms that the rest of the current period keeps the old shape and that every change lands on the next count-0 cycle. A last sequence sets only one of the two run bits and confirms that the counter stays at 0 at the inactive level.

// File: rtl/pwm_lock_pkg.sv
package pwm_lock_pkg;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_CNT  = 4'h0;
  localparam logic [ADDR_W-1:0] OFF_PER  = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_DUTY = 4'h8;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 4'hC;

  localparam int unsigned B_EN      = 0;
  localparam int unsigned B_CONT    = 1;
  localparam int unsigned B_DUTY_HI = 3;
  localparam int unsigned B_IDLE_HI = 4;
  localparam int unsigned B_LOCK    = 6;
endpackage

// File: rtl/pwm_lock_regs.sv
module pwm_lock_regs
  import pwm_lock_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              bound_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              run_o,
  output logic [DATA_W-1:0] act_period_o,
  output logic [DATA_W-1:0] act_duty_o,
  output logic              act_duty_hi_o,
  output logic              act_idle_hi_o
);
  logic [DATA_W-1:0] per_q, duty_q, ctrl_q;
  logic              lock, take;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      duty_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == OFF_PER)  per_q  <= wdata_i;
      if (addr_i == OFF_DUTY) duty_q <= wdata_i;
      if (addr_i == OFF_CTRL) ctrl_q <= wdata_i;
    end
  end

  assign lock  = ctrl_q[B_LOCK];
  assign run_o = ctrl_q[B_EN] & ctrl_q[B_CONT];
  // copy into the active set only between periods or while stopped
  assign take  = !lock && (!run_o || bound_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_period_o  <= '0;
      act_duty_o    <= '0;
      act_duty_hi_o <= 1'b0;
      act_idle_hi_o <= 1'b0;
    end else if (take) begin
      act_period_o  <= per_q;
      act_duty_o    <= duty_q;
      act_duty_hi_o <= ctrl_q[B_DUTY_HI];
      act_idle_hi_o <= ctrl_q[B_IDLE_HI];
    end
  end

  always_comb begin
    unique case (addr_i)
      OFF_CNT:  rdata_o = cnt_i;
      OFF_PER:  rdata_o = per_q;
      OFF_DUTY: rdata_o = duty_q;
      OFF_CTRL: rdata_o = ctrl_q;
      default:  rdata_o = '0;
    endcase
  end

  AST_MID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o && !bound_i |=> $stable(act_period_o) && $stable(act_duty_o)
                          && $stable(act_duty_hi_o) && $stable(act_idle_hi_o)); // R7
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock |=> $stable(act_period_o) && $stable(act_duty_o)); // R8
endmodule

// File: rtl/pwm_lock_core.sv
module pwm_lock_core #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [DATA_W-1:0] period_i,
  input  logic [DATA_W-1:0] duty_i,
  input  logic              duty_hi_i,
  input  logic              idle_hi_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              bound_o,
  output logic              pwm_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] cnt_q;
  logic              per_zero;

  assign per_zero = (period_i == '0);
  assign bound_o  = per_zero || (cnt_q == period_i - ONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (bound_o) cnt_q <= '0;
    else              cnt_q <= cnt_q + ONE;
  end

  always_comb begin
    if (!run_i || per_zero) pwm_o = idle_hi_i;
    else if (cnt_q < duty_i) pwm_o = duty_hi_i;
    else pwm_o = idle_hi_i;
  end

  assign cnt_o = cnt_q;

  AST_CNT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0); // R3
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !per_zero |-> cnt_q < period_i); // R4
  AST_FULL_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !per_zero && duty_i >= period_i |-> pwm_o == duty_hi_i); // R6
endmodule

// File: rtl/pwm_lock_chan.sv
module pwm_lock_chan
  import pwm_lock_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              pwm_o
);
  logic [DATA_W-1:0] cnt, act_period, act_duty;
  logic              bound, run, act_duty_hi, act_idle_hi;

  pwm_lock_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .addr_i        (addr_i),
    .wdata_i       (wdata_i),
    .cnt_i         (cnt),
    .bound_i       (bound),
    .rdata_o       (rdata_o),
    .run_o         (run),
    .act_period_o  (act_period),
    .act_duty_o    (act_duty),
    .act_duty_hi_o (act_duty_hi),
    .act_idle_hi_o (act_idle_hi)
  );

  pwm_lock_core #(.DATA_W(DATA_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .period_i  (act_period),
    .duty_i    (act_duty),
    .duty_hi_i (act_duty_hi),
    .idle_hi_i (act_idle_hi),
    .cnt_o     (cnt),
    .bound_o   (bound),
    .pwm_o     (pwm_o)
  );
endmodule

// File: tb/pwm_lock_chan_tb.sv
`timescale 1ns/100ps
module pwm_lock_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pwm_lock_chan u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  // {period[7:0], duty[7:0], duty_hi, idle_hi}
  localparam logic [17:0] VECS [0:7] = '{
    {8'd5, 8'd2, 1'b1, 1'b0},
    {8'd4, 8'd0, 1'b1, 1'b0},
    {8'd6, 8'd6, 1'b1, 1'b0},
    {8'd7, 8'd9, 1'b0, 1'b1},
    {8'd0, 8'd3, 1'b1, 1'b0},
    {8'd3, 8'd1, 1'b0, 1'b1},
    {8'd1, 8'd1, 1'b1, 1'b0},
    {8'd9, 8'd4, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #0.5;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0; addr = 4'h0; #0.1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #0.1; d = rdata; addr = 4'h0; #0.1;
  endtask

  task automatic wait_cnt(input logic [31:0] v);
    while (rdata !== v) tick();
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r0, r1, r2, r3, c;
    logic [31:0] bad_act, bad_exp;
    bit ok, wrapped;
    int maxc;

    repeat (3) @(posedge clk);
    tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd(4'h0, r0); rd(4'h4, r1); rd(4'h8, r2); rd(4'hC, r3);
    chk(r0 == 0 && r1 == 0 && r2 == 0 && r3 == 0 && pwm == 1'b0, "R1 reset",
        r0 | r1 | r2 | r3 | {31'd0, pwm}, 32'h0);

    // R4 R5 R6 R10 table of waveforms, all programmed while stopped
    for (int v = 0; v < 8; v++) begin
      logic [7:0] p, d;
      logic dh, ih;
      {p, d, dh, ih} = VECS[v];
      wr(4'hC, 32'h0);
      wr(4'h4, {24'd0, p});
      wr(4'h8, {24'd0, d});
      wr(4'hC, {27'd0, ih, dh, 3'b000});
      wr(4'hC, {27'd0, ih, dh, 3'b011});
      ok = 1'b1; bad_act = 0; bad_exp = 0;
      for (int i = 0; i < 20; i++) begin
        logic [31:0] ce;
        logic oe;
        ce = (p == 0) ? 32'd0 : 32'(i % p);
        oe = (p != 0 && ce < {24'd0, d}) ? dh : ih;
        if (ok && (rdata !== ce || pwm !== oe)) begin
          ok = 1'b0; bad_act = {rdata[30:0], pwm}; bad_exp = {ce[30:0], oe};
        end
        tick();
      end
      chk(ok, $sformatf("R4/R5/R6/R10 vector %0d {cnt,out}", v), bad_act, bad_exp);
    end

    // R7 unlocked duty change mid-period waits for the boundary
    wr(4'hC, 32'h0);
    wr(4'h4, 32'd8);
    wr(4'h8, 32'd2);
    wr(4'hC, 32'h08);
    wr(4'hC, 32'h0B);
    wait_cnt(32'd3);
    wr(4'h8, 32'd6);
    ok = 1'b1; wrapped = 1'b0; bad_act = 0; bad_exp = 0;
    for (int i = 0; i < 12; i++) begin
      logic oe;
      c = rdata;
      if (c == 0) wrapped = 1'b1;
      oe = (c < (wrapped ? 32'd6 : 32'd2));
      if (ok && (pwm !== oe || c >= 8 || (i == 0 && c != 4))) begin
        ok = 1'b0; bad_act = {c[30:0], pwm}; bad_exp = {c[30:0], oe};
      end
      tick();
    end
    chk(ok && wrapped, "R7 mid-period duty write", bad_act, bad_exp);

    // R8 lock: staged values read back, waveform unchanged
    wait_cnt(32'd5);
    wr(4'hC, 32'h4B);
    wr(4'h4, 32'd4);
    wr(4'h8, 32'd3);
    rd(4'h4, r1); rd(4'h8, r2);
    chk(r1 == 4 && r2 == 3, "R2/R8 staged readback", {r1[15:0], r2[15:0]}, {16'd4, 16'd3});
    ok = 1'b1; maxc = 0; bad_act = 0; bad_exp = 0;
    for (int i = 0; i < 16; i++) begin
      logic oe;
      c = rdata;
      if (int'(c) > maxc) maxc = int'(c);
      oe = (c < 32'd6);
      if (ok && (pwm !== oe || c >= 8)) begin
        ok = 1'b0; bad_act = {c[30:0], pwm}; bad_exp = {c[30:0], oe};
      end
      tick();
    end
    chk(ok && maxc == 7, "R8 locked waveform holds", bad_act | 32'(maxc), bad_exp | 32'd7);

    // R9 unlock with polarity flip mid-period: all changes at next count 0
    wait_cnt(32'd3);
    wr(4'hC, 32'h13);
    ok = 1'b1; wrapped = 1'b0; bad_act = 0; bad_exp = 0;
    for (int i = 0; i < 12; i++) begin
      logic oe;
      c = rdata;
      if (c == 0) wrapped = 1'b1;
      oe = wrapped ? (c >= 32'd3) : (c < 32'd6);
      if (ok && (pwm !== oe || (wrapped && c >= 4) || (i == 0 && c != 4))) begin
        ok = 1'b0; bad_act = {c[30:0], pwm}; bad_exp = {c[30:0], oe};
      end
      tick();
    end
    chk(ok && wrapped, "R9 joint switch at boundary", bad_act, bad_exp);

    // R3 only one run bit set: counter held, inactive level
    wr(4'hC, 32'h11);
    tick(); tick();
    ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (rdata !== 0 || pwm !== 1'b1) ok = 1'b0;
      tick();
    end
    chk(ok, "R3 enable without continuous", {rdata[30:0], pwm}, 32'h1);
    wr(4'hC, 32'h12);
    tick(); tick();
    ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (rdata !== 0 || pwm !== 1'b1) ok = 1'b0;
      tick();
    end
    chk(ok, "R3 continuous without enable", {rdata[30:0], pwm}, 32'h1);

    // R2 counter write ignored, control readback
    wr(4'h0, 32'h55);
    tick();
    chk(rdata == 0, "R2 counter write ignored", rdata, 32'h0);
    rd(4'hC, r3);
    chk(r3 == 32'h12, "R2 control readback", r3, 32'h12);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule